// File: doc/BRIEF.md
# Reordering DRAM Command Scheduler

This block sits between a stream of read requests and a single DRAM channel with several banks. Each incoming request carries a physical address and a tag. The address is split into a row, a bank and a column. The request waits in a small queue. Each cycle, the block chooses one bank command to place on the shared command bus: row open, column read or bank close. It keeps track of the open row and the remaining busy time of every bank, so it only issues commands that are legal.

Service order is first-ready first-come-first-served. Any queued request whose bank is idle and already holds the wanted row is read before older requests that first need their bank closed and reopened. Among requests that need a row change, the oldest one with an idle bank goes first. A parameter sets the page policy. With the open-row policy, a row stays open after a read. With the close-row policy, every read is followed at once by a close of that bank. Each finished request is reported with its tag, in the cycle of its column read.

Top module: `dram_sched`

## Requirements
- R1: After reset the queue reports empty (`q_empty`=1, `q_full`=0), and no command or completion is presented.
- R2: The address is decoded as {row, bank, column}, with the column in the low bits and the row in the high bits. The bank, row and column fields of the issued commands carry these decoded values.
- R3: A request to a closed bank produces a row-open command, and then its column read exactly T_ACT (3) cycles later. A bank receives no new command while it is occupied.
- R4: A request to a bank holding a different row produces a close, then a row-open T_PRE (3) cycles after the close, then the read T_ACT (3) cycles after the row-open.
- R5: A ready request that hits an open row is read before an older queued request that needs a row change.
- R6: Among requests that need a row change, the oldest is served first.
- R7: At most one command is issued per cycle. Commands to different banks overlap in time: a second bank can be opened in the cycle after the first one.
- R8: With the open-row policy (CLOSE_ROW=0), the row stays open, and a later request to that row is served by a read alone, with no new row-open.
- R9: With the close-row policy (CLOSE_ROW=1), each column read is followed in the next cycle by a close of the same bank. A later request to the same row must therefore open the row again.
- R10: `q_full` rises when the queue holds QDEPTH requests. A request presented while `q_full`=1 is dropped and never completes. `q_full` and `q_empty` are never both high.
- R11: `done_valid` pulses with the request's tag in `done_id` in the cycle of its column read, and only while the queue is not empty.
- R12: Command codes on `cmd_type`: 1 = row open, 2 = column read, 3 = bank close. No command is presented with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New read request present |
| req_addr | input | ROW_W+BANK_W+COL_W | Physical address {row, bank, column} |
| req_id | input | ID_W | Request tag |
| q_full | output | 1 | Queue holds QDEPTH requests; new requests are dropped |
| q_empty | output | 1 | Queue holds no request |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_type | output | 2 | 1 open row, 2 column read, 3 close bank |
| cmd_bank | output | BANK_W | Target bank |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| done_valid | output | 1 | A request completes this cycle |
| done_id | output | ID_W | Tag of the completed request |

## Verification
The bench builds two instances with 4 banks, an 8-entry queue, 4-bit rows and tags, 3-bit columns and busy times of 3/3/1 cycles. The only difference between them is the page policy: one uses the open-row policy and the other the close-row policy. Running the same request stream into both shows, side by side, a row hit served by a read alone and the same hit forced through a close and a reopen. The short busy times make it possible to measure the exact spacing between commands. The 8-entry queue fills within a dozen back-to-back requests to one bank, which reaches the dropped-request case.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;
endpackage

// File: rtl/dram_sched_bank.sv
module dram_sched_bank
  import dram_sched_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int T_PRE     = 3,
  parameter int T_ACT     = 3,
  parameter int T_COL     = 1,
  parameter bit CLOSE_ROW = 1'b0,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] cur_row,
  output logic             ready,
  output logic             close_due
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CNT_W-1:0] busy_q, busy_d;
  logic             due_q, due_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    due_d  = due_q;
    busy_d = (busy_q != '0) ? busy_q - 1'b1 : busy_q;
    if (sel) begin
      unique case (cmd)
        CMD_ACT: begin
          open_d = 1'b1;
          row_d  = row_in;
          busy_d = CNT_W'(T_ACT - 1);
        end
        CMD_RD: begin
          busy_d = CNT_W'(T_COL - 1);
          due_d  = CLOSE_ROW;
        end
        CMD_PRE: begin
          open_d = 1'b0;
          due_d  = 1'b0;
          busy_d = CNT_W'(T_PRE - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      due_q  <= 1'b0;
      busy_q <= '0;
    end else begin
      open_q <= open_d;
      due_q  <= due_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sel) row_q <= row_d;
  end

  assign is_open   = open_q;
  assign cur_row   = row_q;
  assign ready     = (busy_q == '0);
  assign close_due = due_q;
endmodule

// File: rtl/dram_sched_queue.sv
module dram_sched_queue #(
  parameter int QD     = 8,
  parameter int ID_W   = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [ID_W-1:0]            push_id,
  input  logic [BANK_W-1:0]          push_bank,
  input  logic [ROW_W-1:0]           push_row,
  input  logic [COL_W-1:0]           push_col,
  input  logic                       pop,
  input  logic [IDX_W-1:0]           pop_idx,
  output logic [QD-1:0]              valid,
  output logic [QD-1:0][ID_W-1:0]    ids,
  output logic [QD-1:0][BANK_W-1:0]  banks,
  output logic [QD-1:0][ROW_W-1:0]   rows,
  output logic [QD-1:0][COL_W-1:0]   cols,
  output logic                       full,
  output logic                       empty
);
  logic [CNT_W-1:0]            cnt_q, cnt_d, cnt_mid;
  logic [QD-1:0][ID_W-1:0]     id_q, id_d;
  logic [QD-1:0][BANK_W-1:0]   bk_q, bk_d;
  logic [QD-1:0][ROW_W-1:0]    rw_q, rw_d;
  logic [QD-1:0][COL_W-1:0]    cl_q, cl_d;
  logic                        push_ok, upd_en;

  assign full    = (cnt_q == CNT_W'(QD));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign upd_en  = push_ok || pop;

  always_comb begin
    id_d = id_q;
    bk_d = bk_q;
    rw_d = rw_q;
    cl_d = cl_q;
    // close the gap left by the removed entry; index 0 stays oldest
    for (int i = 0; i < QD - 1; i++) begin
      if (pop && i >= int'(pop_idx)) begin
        id_d[i] = id_q[i+1];
        bk_d[i] = bk_q[i+1];
        rw_d[i] = rw_q[i+1];
        cl_d[i] = cl_q[i+1];
      end
    end
    cnt_mid = cnt_q - CNT_W'(pop);
    if (push_ok) begin
      for (int i = 0; i < QD; i++) begin
        if (CNT_W'(i) == cnt_mid) begin
          id_d[i] = push_id;
          bk_d[i] = push_bank;
          rw_d[i] = push_row;
          cl_d[i] = push_col;
        end
      end
    end
    cnt_d = cnt_mid + CNT_W'(push_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      id_q <= id_d;
      bk_q <= bk_d;
      rw_q <= rw_d;
      cl_q <= cl_d;
    end
  end

  generate
    for (genvar g = 0; g < QD; g++) begin : g_valid
      assign valid[g] = (CNT_W'(g) < cnt_q);
    end
  endgenerate

  assign ids   = id_q;
  assign banks = bk_q;
  assign rows  = rw_q;
  assign cols  = cl_q;
endmodule

// File: rtl/dram_sched_pick.sv
module dram_sched_pick
  import dram_sched_pkg::*;
#(
  parameter int QD     = 8,
  parameter int NB     = 4,
  parameter int ID_W   = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int IDX_W  = 3
) (
  input  logic [QD-1:0]              valid,
  input  logic [QD-1:0][ID_W-1:0]    ids,
  input  logic [QD-1:0][BANK_W-1:0]  banks,
  input  logic [QD-1:0][ROW_W-1:0]   rows,
  input  logic [QD-1:0][COL_W-1:0]   cols,
  input  logic [NB-1:0]              bank_open,
  input  logic [NB-1:0][ROW_W-1:0]   bank_row,
  input  logic [NB-1:0]              bank_rdy,
  input  logic [NB-1:0]              bank_due,
  output logic                       cmd_valid,
  output cmd_e                       cmd,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [ROW_W-1:0]           cmd_row,
  output logic [COL_W-1:0]           cmd_col,
  output logic                       pop,
  output logic [IDX_W-1:0]           pop_idx,
  output logic [ID_W-1:0]            done_id
);
  logic              hit_v, miss_v, due_v, rdy_i, match_i;
  logic [IDX_W-1:0]  hit_i, miss_i;
  logic [BANK_W-1:0] due_b, b;

  always_comb begin
    hit_v  = 1'b0;
    miss_v = 1'b0;
    due_v  = 1'b0;
    hit_i  = '0;
    miss_i = '0;
    due_b  = '0;
    // scan youngest to oldest so the oldest eligible entry wins
    for (int i = QD - 1; i >= 0; i--) begin
      b       = banks[i];
      rdy_i   = valid[i] && bank_rdy[b] && !bank_due[b];
      match_i = bank_open[b] && (bank_row[b] == rows[i]);
      if (rdy_i && match_i) begin
        hit_v = 1'b1;
        hit_i = IDX_W'(i);
      end
      if (rdy_i && !match_i) begin
        miss_v = 1'b1;
        miss_i = IDX_W'(i);
      end
    end
    for (int k = NB - 1; k >= 0; k--) begin
      if (bank_due[k] && bank_rdy[k]) begin
        due_v = 1'b1;
        due_b = BANK_W'(k);
      end
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd       = CMD_NOP;
    cmd_bank  = '0;
    cmd_row   = '0;
    cmd_col   = '0;
    pop       = 1'b0;
    pop_idx   = hit_i;
    if (due_v) begin
      cmd_valid = 1'b1;
      cmd       = CMD_PRE;
      cmd_bank  = due_b;
      cmd_row   = bank_row[due_b];
    end else if (hit_v) begin
      cmd_valid = 1'b1;
      cmd       = CMD_RD;
      cmd_bank  = banks[hit_i];
      cmd_row   = rows[hit_i];
      cmd_col   = cols[hit_i];
      pop       = 1'b1;
    end else if (miss_v) begin
      cmd_valid = 1'b1;
      cmd       = bank_open[banks[miss_i]] ? CMD_PRE : CMD_ACT;
      cmd_bank  = banks[miss_i];
      cmd_row   = rows[miss_i];
      cmd_col   = cols[miss_i];
    end
  end

  assign done_id = ids[hit_i];
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int NBANKS    = 4,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 3,
  parameter int ID_W      = 4,
  parameter int T_PRE     = 3,
  parameter int T_ACT     = 3,
  parameter int T_COL     = 1,
  parameter bit CLOSE_ROW = 1'b0,
  localparam int BANK_W   = $clog2(NBANKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
  input  logic [ID_W-1:0]                 req_id,
  output logic                            q_full,
  output logic                            q_empty,
  output logic                            cmd_valid,
  output logic [1:0]                      cmd_type,
  output logic [BANK_W-1:0]               cmd_bank,
  output logic [ROW_W-1:0]                cmd_row,
  output logic [COL_W-1:0]                cmd_col,
  output logic                            done_valid,
  output logic [ID_W-1:0]                 done_id
);
  localparam int IDX_W  = $clog2(QDEPTH);
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int T_MAX  = (T_PRE > T_ACT) ? ((T_PRE > T_COL) ? T_PRE : T_COL)
                                          : ((T_ACT > T_COL) ? T_ACT : T_COL);
  localparam int BCNT_W = $clog2(T_MAX) + 1;

  logic [QDEPTH-1:0]              q_valid;
  logic [QDEPTH-1:0][ID_W-1:0]    q_ids;
  logic [QDEPTH-1:0][BANK_W-1:0]  q_banks;
  logic [QDEPTH-1:0][ROW_W-1:0]   q_rows;
  logic [QDEPTH-1:0][COL_W-1:0]   q_cols;
  logic [NBANKS-1:0]              b_open, b_rdy, b_due;
  logic [NBANKS-1:0][ROW_W-1:0]   b_row;
  logic                           pop;
  logic [IDX_W-1:0]               pop_idx;
  cmd_e                           cmd_sel;

  dram_sched_queue #(
    .QD(QDEPTH), .ID_W(ID_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .IDX_W(IDX_W), .CNT_W(QCNT_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_id   (req_id),
    .push_bank (req_addr[COL_W +: BANK_W]),
    .push_row  (req_addr[COL_W+BANK_W +: ROW_W]),
    .push_col  (req_addr[COL_W-1:0]),
    .pop       (pop),
    .pop_idx   (pop_idx),
    .valid     (q_valid),
    .ids       (q_ids),
    .banks     (q_banks),
    .rows      (q_rows),
    .cols      (q_cols),
    .full      (q_full),
    .empty     (q_empty)
  );

  dram_sched_pick #(
    .QD(QDEPTH), .NB(NBANKS), .ID_W(ID_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) u_pick (
    .valid     (q_valid),
    .ids       (q_ids),
    .banks     (q_banks),
    .rows      (q_rows),
    .cols      (q_cols),
    .bank_open (b_open),
    .bank_row  (b_row),
    .bank_rdy  (b_rdy),
    .bank_due  (b_due),
    .cmd_valid (cmd_valid),
    .cmd       (cmd_sel),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row),
    .cmd_col   (cmd_col),
    .pop       (pop),
    .pop_idx   (pop_idx),
    .done_id   (done_id)
  );

  generate
    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      dram_sched_bank #(
        .ROW_W(ROW_W), .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL),
        .CLOSE_ROW(CLOSE_ROW), .CNT_W(BCNT_W)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (cmd_valid && (cmd_bank == BANK_W'(g))),
        .cmd       (cmd_sel),
        .row_in    (cmd_row),
        .is_open   (b_open[g]),
        .cur_row   (b_row[g]),
        .ready     (b_rdy[g]),
        .close_due (b_due[g])
      );
    end
  endgenerate

  assign cmd_type   = cmd_sel;
  assign done_valid = pop;
endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
  parameter bit CLOSE_ROW = 1'b0,
  parameter int T_COL     = 1,
  parameter int BANK_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_type,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              q_full,
  input logic              q_empty,
  input logic              done_valid
);
  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  // R11
  done_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !q_empty);

  // R12
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_type != 2'd0));

  // R3
  bank_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_type == 2'd1 || cmd_type == 2'd3))
      |=> !(cmd_valid && cmd_bank == $past(cmd_bank)));

  generate
    if (CLOSE_ROW && T_COL == 1) begin : g_close
      // R9
      close_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd2)
          |=> (cmd_valid && cmd_type == 2'd3 && cmd_bank == $past(cmd_bank)));
    end
  endgenerate
endmodule

bind dram_sched dram_sched_chk #(
  .CLOSE_ROW(CLOSE_ROW), .T_COL(T_COL), .BANK_W(BANK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_type   (cmd_type),
  .cmd_bank   (cmd_bank),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .done_valid (done_valid)
);

// File: tb/dram_sched_tb.sv
module dram_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_id = '0;

  logic q_full, q_empty, cmd_valid, done_valid;
  logic [1:0] cmd_type, cmd_bank;
  logic [3:0] cmd_row, done_id;
  logic [2:0] cmd_col;
  logic c_full, c_empty, c_cmd_valid, c_done_valid;
  logic [1:0] c_cmd_type, c_cmd_bank;
  logic [3:0] c_cmd_row, c_done_id;
  logic [2:0] c_cmd_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_sched #(.CLOSE_ROW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_id(req_id), .q_full(q_full), .q_empty(q_empty), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done_valid(done_valid), .done_id(done_id));

  dram_sched #(.CLOSE_ROW(1'b1)) u_dut_cl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_id(req_id), .q_full(c_full), .q_empty(c_empty), .cmd_valid(c_cmd_valid),
    .cmd_type(c_cmd_type), .cmd_bank(c_cmd_bank), .cmd_row(c_cmd_row), .cmd_col(c_cmd_col),
    .done_valid(c_done_valid), .done_id(c_done_id));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_log, n_done, n_cl;
  int l_type[64], l_bank[64], l_row[64], l_col[64], l_cyc[64];
  int d_id[64];
  int c_type[64], c_bank[64], c_cyc[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_log = 0; n_done = 0; n_cl = 0;
    end else begin
      if (cmd_valid && n_log < 64) begin
        l_type[n_log] = int'(cmd_type); l_bank[n_log] = int'(cmd_bank);
        l_row[n_log] = int'(cmd_row); l_col[n_log] = int'(cmd_col);
        l_cyc[n_log] = cyc; n_log++;
      end
      if (done_valid && n_done < 64) begin
        d_id[n_done] = int'(done_id); n_done++;
      end
      if (c_cmd_valid && n_cl < 64) begin
        c_type[n_cl] = int'(c_cmd_type); c_bank[n_cl] = int'(c_cmd_bank);
        c_cyc[n_cl] = cyc; n_cl++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int col);
    return {row[3:0], bank[1:0], col[2:0]};
  endfunction

  task automatic push(input int row, input int bank, input int col, input int id);
    req_valid = 1'b1;
    req_addr = mk(row, bank, col);
    req_id = id[3:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(q_empty == 1'b1, "R1 q_empty", int'(q_empty), 1);
    chk(q_full == 1'b0, "R1 q_full", int'(q_full), 0);
    chk(cmd_valid == 1'b0 && done_valid == 1'b0, "R1 idle", int'(cmd_valid), 0);
  endtask

  task automatic t_open_policy();
    do_reset();
    push(5, 2, 3, 7);
    settle(10);
    chk(n_log == 2, "R3 cmd count", n_log, 2);
    chk(l_type[0] == 1 && l_type[1] == 2, "R12 open then read", l_type[0], 1);
    chk(l_bank[1] == 2 && l_row[1] == 5 && l_col[1] == 3, "R2 fields", l_row[1], 5);
    chk(l_cyc[1] - l_cyc[0] == 3, "R3 read spacing", l_cyc[1] - l_cyc[0], 3);
    chk(n_done == 1 && d_id[0] == 7, "R11 done id", d_id[0], 7);
    push(5, 2, 4, 8);
    settle(8);
    chk(n_log == 3 && l_type[2] == 2, "R8 hit needs read only", n_log, 3);
    chk(l_col[2] == 4 && d_id[1] == 8, "R8 hit col/id", l_col[2], 4);
    push(9, 2, 0, 9);
    settle(14);
    chk(n_log == 6, "R4 cmd count", n_log, 6);
    chk(l_type[3] == 3 && l_type[4] == 1 && l_type[5] == 2, "R4 close/open/read", l_type[3], 3);
    chk(l_cyc[4] - l_cyc[3] == 3, "R4 open after close", l_cyc[4] - l_cyc[3], 3);
    chk(l_cyc[5] - l_cyc[4] == 3 && l_row[5] == 9, "R4 read after open", l_cyc[5] - l_cyc[4], 3);
  endtask

  task automatic t_overlap();
    do_reset();
    push(1, 0, 0, 1);
    push(1, 1, 0, 2);
    settle(12);
    chk(n_log == 4, "R7 cmd count", n_log, 4);
    chk(l_bank[0] == 0 && l_bank[1] == 1 && l_type[1] == 1, "R7 second open bank1", l_bank[1], 1);
    chk(l_cyc[1] - l_cyc[0] == 1, "R7 open overlap", l_cyc[1] - l_cyc[0], 1);
    chk(l_cyc[2] - l_cyc[0] == 3 && l_cyc[3] - l_cyc[0] == 4, "R7 reads", l_cyc[3] - l_cyc[0], 4);
  endtask

  task automatic t_frfcfs();
    do_reset();
    push(2, 0, 0, 1);
    push(6, 0, 0, 2);
    push(2, 0, 1, 3);
    settle(20);
    chk(n_done == 3, "R5 completions", n_done, 3);
    chk(d_id[1] == 3, "R5 younger hit first", d_id[1], 3);
    chk(d_id[2] == 2, "R5 older miss last", d_id[2], 2);
  endtask

  task automatic t_oldest_miss();
    do_reset();
    push(1, 3, 0, 4);
    push(2, 3, 0, 5);
    push(3, 3, 0, 6);
    settle(30);
    chk(n_done == 3, "R6 completions", n_done, 3);
    chk(d_id[1] == 5 && d_id[2] == 6, "R6 oldest miss first", d_id[1], 5);
  endtask

  task automatic t_close();
    do_reset();
    push(3, 1, 0, 1);
    push(3, 1, 1, 2);
    settle(20);
    chk(n_cl == 6, "R9 cmd count", n_cl, 6);
    chk(c_type[0] == 1 && c_type[1] == 2 && c_type[2] == 3, "R9 read then close", c_type[2], 3);
    chk(c_cyc[2] - c_cyc[1] == 1 && c_bank[2] == 1, "R9 close next cycle", c_cyc[2] - c_cyc[1], 1);
    chk(c_type[3] == 1 && c_cyc[3] - c_cyc[2] == 3, "R9 reopen", c_cyc[3] - c_cyc[2], 3);
    chk(c_type[4] == 2 && c_type[5] == 3, "R9 second read closed", c_type[5], 3);
    chk(n_log == 3 && l_type[2] == 2, "R8 open policy same stream", n_log, 3);
  endtask

  task automatic t_full();
    int acc = 0;
    bit saw_full = 1'b0;
    bit dropped_done = 1'b0;
    do_reset();
    for (int k = 0; k < 11; k++) begin
      req_valid = 1'b1;
      req_addr = mk(k, 0, 0);
      if (q_full) begin
        saw_full = 1'b1;
        req_id = 4'd15;
      end else begin
        acc++;
        req_id = k[3:0];
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    chk(saw_full, "R10 full seen", int'(saw_full), 1);
    settle(120);
    chk(q_empty == 1'b1 && q_full == 1'b0, "R10 drained", int'(q_empty), 1);
    chk(n_done == acc, "R10 accepted completions", n_done, acc);
    for (int j = 0; j < n_done; j++) if (d_id[j] == 15) dropped_done = 1'b1;
    chk(!dropped_done, "R10 dropped never done", int'(dropped_done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_open_policy();
    t_overlap();
    t_frfcfs();
    t_oldest_miss();
    t_close();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule